// File: doc/BRIEF.md
# Stochastic Bit-Stream Arithmetic Unit

This unit performs one arithmetic operation on two 8-bit unsigned operands in the stochastic domain. Each operand is expanded into a 256-bit deterministic stream, one bit per clock. A stream encodes a value as the fraction of its bits that are 1, and every position carries equal weight. A single two-input gate network combines the two streams one bit at a time. A counter adds up the ones in the output stream, and its final value is the binary result. The network supports multiplication, minimum, maximum, absolute difference and approximate addition. Every gate in it is built only from NOR and NOT primitives.

The operation code chooses how the second stream is generated. In correlated mode both operands are compared against the same up-counting index. In independent mode the second operand is compared against the bit-reversed index. For reliability studies, a built-in soft-error injector can flip the two input-stream bits, the gate output bit, or both. A free-running 16-bit LFSR sets the flip pattern, and a programmable threshold sets the flip rate.

A three-state controller sequences each run:
- State IDLE waits. The transition IDLE→RUN is taken on `start`, and it latches the operands and the operation.
- State RUN steps the stream index from 0 to 255. The transition RUN→RUN repeats while the index is below 255, and RUN→FIN is taken once the bit at index 255 has been counted.
- State FIN raises `done` for one cycle. The transition FIN→IDLE follows unconditionally.

Top module: `sc_stream_alu`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `result` is 0.
- R2: At index i (0..255) the first stream bit is (A > i). The second stream bit is (B > i) in correlated mode and (B > rev(i)) in independent mode, where rev reverses the order of the 8 index bits. Op code 0 (multiply) takes the AND of the independent streams, and the result is the count of ones.
- R3: Op code 1 (minimum) takes the AND of the correlated streams and gives exactly min(A,B).
- R4: Op code 2 (maximum) takes the OR of the correlated streams and gives exactly max(A,B).
- R5: Op code 3 (absolute difference) takes the XOR of the correlated streams and gives exactly |A−B|.
- R6: Op code 4 (approximate addition) takes the OR of the independent streams.
- R7: Op codes 5, 6 and 7 behave exactly like op code 0.
- R8: If `start` is accepted at clock edge E0, `busy` is 1 from E0 to E256, `done` is 1 for exactly the cycle that follows E256, and `result` changes only at the edge that raises `done`. Outside that edge, `result` holds its value until the next `done`.
- R9: A `start` raised while `busy` is 1 is ignored. The run in progress finishes with its own operands and timing, and no second run follows it.
- R10: An output count of 256 is reported as 255.
- R11: A flip event occurs in a cycle when the LFSR value is less than or equal to `flt_thresh`. The LFSR never holds 0, so a threshold of 0 never flips and a threshold of 0xFFFF flips every cycle. `flt_in_en` inverts both stream bits on a flip event, and `flt_gate_en` inverts the gate output bit.
- R12: With gate faults at a threshold of 0x0400, the result stays within 32 of its fault-free value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run when idle |
| op | input | 3 | Operation code |
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand |
| flt_in_en | input | 1 | Enable flips on both stream bits |
| flt_gate_en | input | 1 | Enable flips on the gate output bit |
| flt_thresh | input | 16 | Flip threshold compared against the LFSR |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 8 | Saturated count of output ones |

## Verification
The hardest condition to reach from the ports is a full count of 256, which saturation must clip. Fault-free streams can hold at most 255 ones, so no choice of operands reaches it. The stimulus reaches it by running maximum on two zero operands with gate flips at a threshold of all ones, which turns every output bit into a 1. The same all-ones threshold makes the other fault cases exact: inverting the inputs of minimum must give 256 − max(A,B), and inverting the gate output must give 256 − min(A,B).

// File: rtl/sc_alu_pkg.sv
package sc_alu_pkg;

    localparam logic [2:0] OP_MUL  = 3'd0;
    localparam logic [2:0] OP_MIN  = 3'd1;
    localparam logic [2:0] OP_MAX  = 3'd2;
    localparam logic [2:0] OP_ADIF = 3'd3;
    localparam logic [2:0] OP_ADD  = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } sc_state_e;

    function automatic logic nor2(input logic x, input logic y);
        return ~(x | y);
    endfunction

    function automatic logic inv1(input logic x);
        return nor2(x, x);
    endfunction

    // Correlated generation only for min, max and absolute difference.
    function automatic logic needs_indep(input logic [2:0] code);
        return !(code == OP_MIN || code == OP_MAX || code == OP_ADIF);
    endfunction

endpackage

// File: rtl/sc_stream_src.sv
module sc_stream_src #(
    parameter int W = 8
) (
    input  logic [W-1:0] idx,
    input  logic [W-1:0] val_a,
    input  logic [W-1:0] val_b,
    input  logic         indep,
    output logic         bit_a,
    output logic         bit_b
);
    logic [W-1:0] idx_rev;

    for (genvar g = 0; g < W; g++) begin : g_rev
        assign idx_rev[g] = idx[W-1-g];
    end

    logic [W-1:0] ref_b;
    assign ref_b = indep ? idx_rev : idx;

    assign bit_a = (val_a > idx);
    assign bit_b = (val_b > ref_b);
endmodule

// File: rtl/sc_flip_src.sv
module sc_flip_src #(
    parameter int          LW   = 16,
    parameter logic [LW-1:0] SEED = 16'hACE1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] thresh,
    output logic          hit
);
    logic [LW-1:0] lfsr_q;
    logic          fb;

    // x^16 + x^14 + x^13 + x^11 + 1, maximal length
    assign fb = lfsr_q[LW-1] ^ lfsr_q[LW-3] ^ lfsr_q[LW-4] ^ lfsr_q[LW-6];

    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= SEED;
        else        lfsr_q <= {lfsr_q[LW-2:0], fb};
    end

    assign hit = (lfsr_q <= thresh);
endmodule

// File: rtl/sc_nor_net.sv
module sc_nor_net
    import sc_alu_pkg::*;
(
    input  logic       xa,
    input  logic       xb,
    input  logic [2:0] op,
    output logic       y
);
    logic na, nb, g_nor, g_and, g_or, g_xor;

    always_comb begin
        na    = inv1(xa);
        nb    = inv1(xb);
        g_nor = nor2(xa, xb);
        g_and = nor2(na, nb);
        g_or  = inv1(g_nor);
        g_xor = nor2(g_nor, g_and);
    end

    always_comb begin
        unique case (op)
            OP_MIN:          y = g_and;
            OP_MAX, OP_ADD:  y = g_or;
            OP_ADIF:         y = g_xor;
            default:         y = g_and;
        endcase
    end
endmodule

// File: rtl/sc_stream_alu.sv
module sc_stream_alu
    import sc_alu_pkg::*;
#(
    parameter int W  = 8,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    op,
    input  logic [W-1:0]  opnd_a,
    input  logic [W-1:0]  opnd_b,
    input  logic          flt_in_en,
    input  logic          flt_gate_en,
    input  logic [LW-1:0] flt_thresh,
    output logic          busy,
    output logic          done,
    output logic [W-1:0]  result
);
    localparam int CW = W + 1;

    sc_state_e     state_q, state_d;
    logic [W-1:0]  idx_q, a_q, b_q, res_q;
    logic [2:0]    op_q;
    logic [CW-1:0] acc_q, acc_nxt;
    logic          last_idx;
    logic          sa, sb, fa, fb, gy, gy_f, hit;

    sc_stream_src #(.W(W)) u_src (
        .idx   (idx_q),
        .val_a (a_q),
        .val_b (b_q),
        .indep (needs_indep(op_q)),
        .bit_a (sa),
        .bit_b (sb)
    );

    sc_flip_src #(.LW(LW)) u_flip (
        .clk    (clk),
        .rst_n  (rst_n),
        .thresh (flt_thresh),
        .hit    (hit)
    );

    assign fa = sa ^ (flt_in_en & hit);
    assign fb = sb ^ (flt_in_en & hit);

    sc_nor_net u_net (
        .xa (fa),
        .xb (fb),
        .op (op_q),
        .y  (gy)
    );

    assign gy_f     = gy ^ (flt_gate_en & hit);
    assign last_idx = (idx_q == {W{1'b1}});
    assign acc_nxt  = acc_q + {{(CW-1){1'b0}}, gy_f};

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)    state_d = ST_RUN;
            ST_RUN:  if (last_idx) state_d = ST_FIN;
            ST_FIN:                state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            acc_q <= '0;
            a_q   <= '0;
            b_q   <= '0;
            op_q  <= OP_MUL;
            res_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        idx_q <= '0;
                        acc_q <= '0;
                        a_q   <= opnd_a;
                        b_q   <= opnd_b;
                        op_q  <= op;
                    end
                end
                ST_RUN: begin
                    idx_q <= idx_q + {{(W-1){1'b0}}, 1'b1};
                    acc_q <= acc_nxt;
                    if (last_idx)
                        res_q <= acc_nxt[CW-1] ? {W{1'b1}} : acc_nxt[W-1:0];
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy   = (state_q == ST_RUN);
        done   = (state_q == ST_FIN);
        result = res_q;
    end
endmodule

// File: rtl/sc_stream_alu_chk.sv
module sc_stream_alu_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] result
);
    localparam int RUNLEN = 1 << W;

    logic [W:0] run_len;

    always_ff @(posedge clk) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    // R8
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    busy_fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);

    // R9
    run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_len == RUNLEN[W:0]));
endmodule

bind sc_stream_alu sc_stream_alu_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .done   (done),
    .result (result)
);

// File: tb/sim_sc_stream_alu.sv
`timescale 1ns/1ps
module sim_sc_stream_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [7:0]  opnd_a = 8'd0, opnd_b = 8'd0;
    logic        flt_in_en = 1'b0, flt_gate_en = 1'b0;
    logic [15:0] flt_thresh = 16'd0;
    logic        busy, done;
    logic [7:0]  result;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sc_stream_alu u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .opnd_a(opnd_a), .opnd_b(opnd_b),
        .flt_in_en(flt_in_en), .flt_gate_en(flt_gate_en), .flt_thresh(flt_thresh),
        .busy(busy), .done(done), .result(result)
    );

    function automatic int rev8(input int i);
        int r = 0;
        for (int k = 0; k < 8; k++) if (i[k]) r |= (1 << (7 - k));
        return r;
    endfunction

    // counts per stream definition: and (is_or=0) or or (is_or=1) of independent streams
    function automatic int indep_count(input int a, input int b, input bit is_or);
        int c = 0;
        for (int i = 0; i < 256; i++) begin
            bit x = (a > i);
            bit y = (b > rev8(i));
            if (is_or ? (x | y) : (x & y)) c++;
        end
        return c;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // start a run; returns result and edges from accept to done
    task automatic run(input int a, input int b, input int code,
                       input bit fi, input bit fg, input int th,
                       output int res, output int cyc);
        @(negedge clk);
        opnd_a = a[7:0]; opnd_b = b[7:0]; op = code[2:0];
        flt_in_en = fi; flt_gate_en = fg; flt_thresh = th[15:0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R8 busy after accept", busy, 1);
        cyc = 0;
        while (!done && cyc < 400) begin
            @(negedge clk);
            cyc++;
        end
        res = result;
    endtask

    task automatic t_reset();
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 result", result, 0);
    endtask

    task automatic t_mul();
        int r, c;
        run(128, 128, 0, 0, 0, 0, r, c);
        check("R2 mul 128x128", r, 64);
        check("R8 run length", c, 256);
        run(200, 77, 0, 0, 0, 0, r, c);
        check("R2 mul 200x77", r, indep_count(200, 77, 0));
        run(255, 255, 0, 0, 0, 0, r, c);
        check("R2 mul 255x255", r, 255);
        run(0, 255, 0, 0, 0, 0, r, c);
        check("R2 mul 0x255", r, 0);
    endtask

    task automatic t_minmax();
        int r, c;
        run(200, 100, 1, 0, 0, 0, r, c);
        check("R3 min", r, 100);
        run(37, 190, 1, 0, 0, 0, r, c);
        check("R3 min swapped", r, 37);
        run(200, 100, 2, 0, 0, 0, r, c);
        check("R4 max", r, 200);
        run(0, 255, 2, 0, 0, 0, r, c);
        check("R4 max edge", r, 255);
    endtask

    task automatic t_adif_add();
        int r, c;
        run(50, 180, 3, 0, 0, 0, r, c);
        check("R5 absdiff", r, 130);
        run(99, 99, 3, 0, 0, 0, r, c);
        check("R5 absdiff equal", r, 0);
        run(100, 60, 4, 0, 0, 0, r, c);
        check("R6 add", r, indep_count(100, 60, 1));
        run(6, 6, 4, 0, 0, 0, r, c);
        check("R6 add small", r, indep_count(6, 6, 1));
    endtask

    task automatic t_unused();
        int r, c;
        run(200, 77, 6, 0, 0, 0, r, c);
        check("R7 code 6", r, indep_count(200, 77, 0));
        run(150, 33, 5, 0, 0, 0, r, c);
        check("R7 code 5", r, indep_count(150, 33, 0));
    endtask

    task automatic t_restart();
        int c;
        @(negedge clk);
        opnd_a = 8'd200; opnd_b = 8'd100; op = 3'd1;
        flt_in_en = 0; flt_gate_en = 0; flt_thresh = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (50) @(negedge clk);
        opnd_a = 8'd10; opnd_b = 8'd20; op = 3'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        c = 51;
        while (!done && c < 400) begin
            @(negedge clk);
            c++;
        end
        check("R9 result kept", result, 100);
        check("R9 timing kept", c, 256);
        @(negedge clk);
        check("R9 no second run", busy, 0);
        check("R8 done one cycle", done, 0);
        check("R8 result held", result, 100);
    endtask

    task automatic t_faults();
        int r, c;
        run(200, 100, 1, 0, 1, 0, r, c);
        check("R11 threshold zero", r, 100);
        run(200, 100, 1, 0, 1, 16'hFFFF, r, c);
        check("R11 gate flip all", r, 156);
        run(200, 100, 1, 1, 0, 16'hFFFF, r, c);
        check("R11 input flip all", r, 56);
        run(0, 0, 2, 0, 1, 16'hFFFF, r, c);
        check("R10 saturate", r, 255);
        run(128, 128, 0, 0, 1, 16'h0400, r, c);
        r = r - 64;
        if (r < 0) r = -r;
        check("R12 bounded error", (r <= 32) ? 1 : 0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mul();
        t_minmax();
        t_adif_add();
        t_unused();
        t_restart();
        t_faults();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule